// File: doc/BRIEF.md
# Interrupt Domain Register Front End

This block is the software-visible register file of an interrupt domain. It accepts 32-bit register accesses on a simple request/response port and turns them into per-source command pulses (set pending, clear pending, set enable, clear enable). It also holds the domain-wide interrupt-enable flag, a 3-bit mode per source and a target word per source. For reads it packs per-source status bits that the source logic supplies into 32-bit words.

The source logic and the delivery logic sit next to this block and are not part of it. The source logic consumes the command pulses, the per-source mode and the target words. It returns the pending bit, the enable bit and the rectified input level of every source. Source numbers run from 1 to `NUM_SRC`. Number 0 does not exist. A 1 bit in bitmap word w stands for source 32·w + bit. The number of bitmap words is (NUM_SRC + 1 + 31) / 32.

Top module: `irq_dom_regs`

## Requirements
- R1: An access is accepted only when addr_i[1:0] is 0 and be_i is 4'hF. Any other access gives rsp_err_o = 1 with rdata_o = 0 and has no side effect.
- R2: An access to an offset outside every window listed below gives rsp_err_o = 1 with rdata_o = 0.
- R3: At offset 0x0000, a write stores only wdata bit 8 into ie_o. A read returns 32'h8000_0004 OR (ie << 8).
- R4: Offset 0x0004 + 4·k, for k < NUM_SRC, holds the mode of source k+1. A write with bit 10 set stores 0. Otherwise the write stores bits 2:0. A read returns the stored mode. Source s appears on mode_o[3(s-1) +: 3].
- R5: Offset 0x3004 + 4·k, for k < NUM_SRC, holds the target of source k+1. A write stores wdata AND 32'hFFFF_F7FF. A read returns the stored value. Source s appears on target_o[32(s-1) +: 32].
- R6: A write to bitmap word w of a command window gives a one-cycle pulse for source 32·w + b for every 1 bit b, when that source lies in 1..NUM_SRC. The windows are set-pending at 0x1C00, clear-pending at 0x1D00, set-enable at 0x1E00 and clear-enable at 0x1F00. The 0 bits give no pulse.
- R7: A bitmap read returns bit b of word w for source 32·w + b. The source is read as 0 when it is 0 or above NUM_SRC. Reads at 0x1C00 return pend_i. Reads at 0x1D00 return lvl_i. Reads at 0x1E00 return en_i. Reads at 0x1F00 return 0.
- R8: The number ports act on the source whose number is written:
  - set pending: 0x1CDC and 0x2000
  - set pending, with the written value byte-swapped first: 0x2004
  - clear pending: 0x1DDC
  - set enable: 0x1EDC
  - clear enable: 0x1FDC

  A number of 0 or above NUM_SRC gives no pulse. All number ports read 0.
- R9: Every request cycle is followed by exactly one cycle with rsp_valid_o = 1. Command pulses and updated register contents appear in that same cycle. Writes return rdata_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register |
| be_i | input | 4 | Byte enables; must be 4'hF |
| wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response strobe, one cycle after req_i |
| rsp_err_o | output | 1 | Error response |
| rdata_o | output | 32 | Read data, 0 on writes and errors |
| pend_i | input | NUM_SRC | Pending bit per source (bit s-1 = source s) |
| en_i | input | NUM_SRC | Enable bit per source |
| lvl_i | input | NUM_SRC | Rectified input level per source |
| ie_o | output | 1 | Domain interrupt enable |
| mode_o | output | 3·NUM_SRC | Mode per source |
| target_o | output | 32·NUM_SRC | Target word per source |
| set_ip_o | output | NUM_SRC | Set-pending pulse per source |
| clr_ip_o | output | NUM_SRC | Clear-pending pulse per source |
| set_ie_o | output | NUM_SRC | Set-enable pulse per source |
| clr_ie_o | output | NUM_SRC | Clear-enable pulse per source |

## Verification
The pulse that a command write produces and the status sample taken by the next read fall in the same cycle. The source logic only updates its state on the following edge, so a read issued directly after a command write still returns the old status. The bench provokes this with back-to-back write-then-read pairs on the pending and enable bitmaps. A small behavioural source model in the bench applies the pulses one edge later, and each read is judged against that model's state as it stood before the pulse took effect. A second read one access later must then show the new state.

// File: rtl/idr_pkg.sv
package idr_pkg;
  localparam int unsigned OFF_DOMCFG      = 32'h0000;
  localparam int unsigned OFF_SRCCFG      = 32'h0004;
  localparam int unsigned OFF_SETIP       = 32'h1C00;
  localparam int unsigned OFF_SETIPNUM    = 32'h1CDC;
  localparam int unsigned OFF_INLVL       = 32'h1D00;
  localparam int unsigned OFF_CLRIPNUM    = 32'h1DDC;
  localparam int unsigned OFF_SETIE       = 32'h1E00;
  localparam int unsigned OFF_SETIENUM    = 32'h1EDC;
  localparam int unsigned OFF_CLRIE       = 32'h1F00;
  localparam int unsigned OFF_CLRIENUM    = 32'h1FDC;
  localparam int unsigned OFF_SETIPNUM_LE = 32'h2000;
  localparam int unsigned OFF_SETIPNUM_BE = 32'h2004;
  localparam int unsigned OFF_TARGET      = 32'h3004;

  localparam logic [31:0] DOMCFG_FIXED  = 32'h8000_0004;
  localparam int unsigned DOMCFG_IE_BIT = 8;
  localparam int unsigned CFG_DELEG_BIT = 10;
  localparam logic [31:0] TARGET_KEEP   = 32'hFFFF_F7FF;

  typedef enum logic [3:0] {
    REG_NONE, REG_DOMCFG, REG_SRCCFG, REG_TARGET,
    REG_SETIP, REG_INLVL, REG_SETIE, REG_CLRIE,
    REG_SETIPNUM, REG_SETIPNUM_LE, REG_SETIPNUM_BE,
    REG_CLRIPNUM, REG_SETIENUM, REG_CLRIENUM
  } reg_kind_e;

  function automatic logic [31:0] bswap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
endpackage

// File: rtl/idr_decode.sv
module idr_decode
  import idr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned NUM_SRC   = 40,
  parameter int unsigned NUM_WORDS = 2,
  parameter int unsigned SEL_W     = 6,
  parameter int unsigned WSEL_W    = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  output reg_kind_e         kind_o,
  output logic [SEL_W-1:0]  src_sel_o,
  output logic [WSEL_W-1:0] word_sel_o,
  output logic              err_o
);
  logic [31:0] off;
  assign off = 32'(addr_i);

  function automatic logic in_win(input logic [31:0] o, input int unsigned base,
                                  input int unsigned n);
    return (o >= base) && (o < base + 4 * n);
  endfunction

  always_comb begin
    kind_o     = REG_NONE;
    src_sel_o  = '0;
    word_sel_o = '0;
    if (off == OFF_DOMCFG) kind_o = REG_DOMCFG;
    else if (in_win(off, OFF_SRCCFG, NUM_SRC)) begin
      kind_o    = REG_SRCCFG;
      src_sel_o = SEL_W'((off - OFF_SRCCFG) >> 2);
    end else if (in_win(off, OFF_TARGET, NUM_SRC)) begin
      kind_o    = REG_TARGET;
      src_sel_o = SEL_W'((off - OFF_TARGET) >> 2);
    end else if (in_win(off, OFF_SETIP, NUM_WORDS)) begin
      kind_o     = REG_SETIP;
      word_sel_o = WSEL_W'((off - OFF_SETIP) >> 2);
    end else if (in_win(off, OFF_INLVL, NUM_WORDS)) begin
      kind_o     = REG_INLVL;
      word_sel_o = WSEL_W'((off - OFF_INLVL) >> 2);
    end else if (in_win(off, OFF_SETIE, NUM_WORDS)) begin
      kind_o     = REG_SETIE;
      word_sel_o = WSEL_W'((off - OFF_SETIE) >> 2);
    end else if (in_win(off, OFF_CLRIE, NUM_WORDS)) begin
      kind_o     = REG_CLRIE;
      word_sel_o = WSEL_W'((off - OFF_CLRIE) >> 2);
    end
    else if (off == OFF_SETIPNUM)    kind_o = REG_SETIPNUM;
    else if (off == OFF_SETIPNUM_LE) kind_o = REG_SETIPNUM_LE;
    else if (off == OFF_SETIPNUM_BE) kind_o = REG_SETIPNUM_BE;
    else if (off == OFF_CLRIPNUM)    kind_o = REG_CLRIPNUM;
    else if (off == OFF_SETIENUM)    kind_o = REG_SETIENUM;
    else if (off == OFF_CLRIENUM)    kind_o = REG_CLRIENUM;
  end

  assign err_o = (addr_i[1:0] != 2'b00) || (be_i != 4'hF) || (kind_o == REG_NONE);
endmodule

// File: rtl/idr_cfg_store.sv
module idr_cfg_store
  import idr_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned SEL_W   = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   mode_we_i,
  input  logic                   tgt_we_i,
  input  logic [SEL_W-1:0]       sel_i,
  input  logic [2:0]             mode_val_i,
  input  logic [31:0]            tgt_val_i,
  output logic [NUM_SRC*3-1:0]   mode_o,
  output logic [NUM_SRC*32-1:0]  target_o,
  output logic [2:0]             mode_rd_o,
  output logic [31:0]            target_rd_o
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [2:0]  mode_q;
    logic [31:0] tgt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_q <= '0;
        tgt_q  <= '0;
      end else begin
        if (mode_we_i && sel_i == SEL_W'(s)) mode_q <= mode_val_i;
        if (tgt_we_i && sel_i == SEL_W'(s))  tgt_q  <= tgt_val_i & TARGET_KEEP;
      end
    end
    assign mode_o[s*3 +: 3]    = mode_q;
    assign target_o[s*32 +: 32] = tgt_q;
  end

  assign mode_rd_o   = (32'(sel_i) < NUM_SRC) ? mode_o[sel_i*3 +: 3] : '0;
  assign target_rd_o = (32'(sel_i) < NUM_SRC) ? target_o[sel_i*32 +: 32] : '0;
endmodule

// File: rtl/idr_word_gather.sv
module idr_word_gather #(
  parameter int unsigned NUM_SRC   = 40,
  parameter int unsigned NUM_WORDS = 2,
  parameter int unsigned WSEL_W    = 1
) (
  input  logic [NUM_SRC-1:0] bits_i,
  input  logic [WSEL_W-1:0]  word_i,
  output logic [31:0]        word_o
);
  localparam int unsigned FULL_W = NUM_WORDS * 32;
  logic [FULL_W-1:0] full;

  // bit 0 of word 0 is the nonexistent source 0
  always_comb begin
    full = '0;
    full[NUM_SRC:1] = bits_i;
  end

  assign word_o = (32'(word_i) < NUM_WORDS) ? full[word_i*32 +: 32] : '0;
endmodule

// File: rtl/irq_dom_regs.sv
module irq_dom_regs
  import idr_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned ADDR_W  = 15
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [3:0]            be_i,
  input  logic [31:0]           wdata_i,
  output logic                  rsp_valid_o,
  output logic                  rsp_err_o,
  output logic [31:0]           rdata_o,
  input  logic [NUM_SRC-1:0]    pend_i,
  input  logic [NUM_SRC-1:0]    en_i,
  input  logic [NUM_SRC-1:0]    lvl_i,
  output logic                  ie_o,
  output logic [NUM_SRC*3-1:0]  mode_o,
  output logic [NUM_SRC*32-1:0] target_o,
  output logic [NUM_SRC-1:0]    set_ip_o,
  output logic [NUM_SRC-1:0]    clr_ip_o,
  output logic [NUM_SRC-1:0]    set_ie_o,
  output logic [NUM_SRC-1:0]    clr_ie_o
);
  localparam int unsigned NUM_WORDS = (NUM_SRC + 1 + 31) / 32;
  localparam int unsigned SEL_W     = $clog2(NUM_SRC + 1);
  localparam int unsigned WSEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int unsigned FULL_W    = NUM_WORDS * 32;

  reg_kind_e         kind;
  logic [SEL_W-1:0]  src_sel;
  logic [WSEL_W-1:0] word_sel;
  logic              dec_err;

  idr_decode #(
    .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .NUM_WORDS(NUM_WORDS),
    .SEL_W(SEL_W), .WSEL_W(WSEL_W)
  ) u_decode (
    .addr_i(addr_i), .be_i(be_i), .kind_o(kind),
    .src_sel_o(src_sel), .word_sel_o(word_sel), .err_o(dec_err)
  );

  logic acc_ok, wr_ok;
  assign acc_ok = req_i && !dec_err;
  assign wr_ok  = acc_ok && we_i;

  logic [2:0]  mode_val, mode_rd;
  logic [31:0] target_rd;
  assign mode_val = wdata_i[CFG_DELEG_BIT] ? 3'd0 : wdata_i[2:0];

  idr_cfg_store #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .mode_we_i(wr_ok && kind == REG_SRCCFG),
    .tgt_we_i(wr_ok && kind == REG_TARGET),
    .sel_i(src_sel), .mode_val_i(mode_val), .tgt_val_i(wdata_i),
    .mode_o(mode_o), .target_o(target_o),
    .mode_rd_o(mode_rd), .target_rd_o(target_rd)
  );

  // one gather shared by the three status windows
  logic [NUM_SRC-1:0] stat_bits;
  logic [31:0]        stat_word;
  always_comb begin
    unique case (kind)
      REG_SETIP: stat_bits = pend_i;
      REG_INLVL: stat_bits = lvl_i;
      REG_SETIE: stat_bits = en_i;
      default:   stat_bits = '0;
    endcase
  end

  idr_word_gather #(.NUM_SRC(NUM_SRC), .NUM_WORDS(NUM_WORDS), .WSEL_W(WSEL_W)) u_gather (
    .bits_i(stat_bits), .word_i(word_sel), .word_o(stat_word)
  );

  // bitmap scatter and number decode
  logic [FULL_W-1:0]  bm_full;
  logic [NUM_SRC-1:0] bm_hit, num_hit;
  logic [31:0]        num_val;
  always_comb begin
    bm_full = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (32'(word_sel) == w) bm_full[w*32 +: 32] = wdata_i;
    bm_hit  = bm_full[NUM_SRC:1];
    num_val = (kind == REG_SETIPNUM_BE) ? bswap32(wdata_i) : wdata_i;
    for (int s = 1; s <= NUM_SRC; s++) num_hit[s-1] = (num_val == 32'(s));
  end

  logic [NUM_SRC-1:0] set_ip_d, clr_ip_d, set_ie_d, clr_ie_d;
  logic [31:0]        rd_mux;
  always_comb begin
    set_ip_d = '0;
    clr_ip_d = '0;
    set_ie_d = '0;
    clr_ie_d = '0;
    if (wr_ok) begin
      unique case (kind)
        REG_SETIP:                                        set_ip_d = bm_hit;
        REG_SETIPNUM, REG_SETIPNUM_LE, REG_SETIPNUM_BE:   set_ip_d = num_hit;
        REG_INLVL:                                        clr_ip_d = bm_hit;
        REG_CLRIPNUM:                                     clr_ip_d = num_hit;
        REG_SETIE:                                        set_ie_d = bm_hit;
        REG_SETIENUM:                                     set_ie_d = num_hit;
        REG_CLRIE:                                        clr_ie_d = bm_hit;
        REG_CLRIENUM:                                     clr_ie_d = num_hit;
        default: ;
      endcase
    end
    unique case (kind)
      REG_DOMCFG:                     rd_mux = DOMCFG_FIXED | (32'(ie_o) << DOMCFG_IE_BIT);
      REG_SRCCFG:                     rd_mux = 32'(mode_rd);
      REG_TARGET:                     rd_mux = target_rd;
      REG_SETIP, REG_INLVL, REG_SETIE: rd_mux = stat_word;
      default:                        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_o        <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rdata_o     <= '0;
      set_ip_o    <= '0;
      clr_ip_o    <= '0;
      set_ie_o    <= '0;
      clr_ie_o    <= '0;
    end else begin
      if (wr_ok && kind == REG_DOMCFG) ie_o <= wdata_i[DOMCFG_IE_BIT];
      rsp_valid_o <= req_i;
      rsp_err_o   <= req_i && dec_err;
      rdata_o     <= (acc_ok && !we_i) ? rd_mux : '0;
      set_ip_o    <= set_ip_d;
      clr_ip_o    <= clr_ip_d;
      set_ie_o    <= set_ie_d;
      clr_ie_o    <= clr_ie_d;
    end
  end
endmodule

// File: rtl/idr_checks.sv
module idr_checks #(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned ADDR_W  = 15
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [3:0]         be_i,
  input logic               rsp_valid_o,
  input logic               rsp_err_o,
  input logic [31:0]        rdata_o,
  input logic               ie_o,
  input logic [NUM_SRC-1:0] set_ip_o,
  input logic [NUM_SRC-1:0] clr_ip_o,
  input logic [NUM_SRC-1:0] set_ie_o,
  input logic [NUM_SRC-1:0] clr_ie_o
);
  logic any_pulse;
  assign any_pulse = (|set_ip_o) || (|clr_ip_o) || (|set_ie_o) || (|clr_ie_o);

  a_r1_err_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rdata_o == 32'd0) && rsp_valid_o);

  a_r1_narrow_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && be_i != 4'hF) |=> rsp_err_o);

  a_r1_misaligned_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[1:0] != 2'b00) |=> rsp_err_o);

  a_r1_err_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> !any_pulse);

  a_r3_ie_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(ie_o));

  a_r6_pulse_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_pulse |-> $past(req_i && we_i));

  a_r8_one_command_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({|set_ip_o, |clr_ip_o, |set_ie_o, |clr_ie_o}));

  a_r9_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);

  a_r9_no_idle_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);

  a_r9_write_data_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |=> (rdata_o == 32'd0));
endmodule

bind irq_dom_regs idr_checks #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_idr_checks (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .be_i(be_i), .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o), .rdata_o(rdata_o),
  .ie_o(ie_o), .set_ip_o(set_ip_o), .clr_ip_o(clr_ip_o), .set_ie_o(set_ie_o),
  .clr_ie_o(clr_ie_o)
);

// File: tb/test_irq_dom_regs.sv
module test_irq_dom_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 40;
  localparam int NW   = 2;
  localparam int AW   = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0]  be = 4'hF;
  logic [31:0] wdata = '0;
  logic rsp_valid, rsp_err, ie;
  logic [31:0] rdata;
  logic [NSRC-1:0] pend_s, en_s, lvl_s;
  logic [NSRC*3-1:0]  mode_v;
  logic [NSRC*32-1:0] tgt_v;
  logic [NSRC-1:0] sip, cip, sie, cie;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dom_regs #(.NUM_SRC(NSRC), .ADDR_W(AW)) i_irq_dom_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .be_i(be),
    .wdata_i(wdata), .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rdata_o(rdata),
    .pend_i(pend_s), .en_i(en_s), .lvl_i(lvl_s), .ie_o(ie), .mode_o(mode_v),
    .target_o(tgt_v), .set_ip_o(sip), .clr_ip_o(cip), .set_ie_o(sie), .clr_ie_o(cie)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model state
  int          mode_m [1:NSRC];
  int unsigned tgt_m  [1:NSRC];
  bit          ie_m;
  bit          exp_valid, exp_err;
  logic [31:0] exp_rdata;
  logic [NSRC-1:0] exp_sip, exp_cip, exp_sie, exp_cie;
  string       exp_tag = "R9";

  function automatic bit src_ok(int s);
    return s >= 1 && s <= NSRC;
  endfunction

  task automatic model(input bit w, input int unsigned a, input logic [3:0] b,
                       input logic [31:0] d);
    int unsigned n;
    int s;
    exp_valid = 1; exp_err = 0; exp_rdata = 0;
    exp_sip = '0; exp_cip = '0; exp_sie = '0; exp_cie = '0;
    if ((a % 4) != 0 || b != 4'hF) begin exp_err = 1; exp_tag = "R1"; return; end
    if (a == 0) begin
      exp_tag = "R3";
      if (w) ie_m = d[8]; else exp_rdata = 32'h8000_0004 | (ie_m ? 32'h100 : 32'h0);
    end else if (a >= 4 && a < 4 + 4*NSRC) begin
      exp_tag = "R4"; s = (a - 4) / 4 + 1;
      if (w) mode_m[s] = d[10] ? 0 : int'(d[2:0]); else exp_rdata = mode_m[s];
    end else if (a >= 'h3004 && a < 'h3004 + 4*NSRC) begin
      exp_tag = "R5"; s = (a - 'h3004) / 4 + 1;
      if (w) tgt_m[s] = d & 32'hFFFF_F7FF; else exp_rdata = tgt_m[s];
    end else if ((a >= 'h1C00 && a < 'h1C00 + 4*NW) || (a >= 'h1D00 && a < 'h1D00 + 4*NW) ||
                 (a >= 'h1E00 && a < 'h1E00 + 4*NW) || (a >= 'h1F00 && a < 'h1F00 + 4*NW)) begin
      int unsigned base = a & 32'h7F00;
      int wd = (a - base) / 4;
      exp_tag = w ? "R6" : "R7";
      for (int bt = 0; bt < 32; bt++) begin
        s = 32*wd + bt;
        if (src_ok(s)) begin
          if (w && d[bt]) begin
            if (base == 'h1C00) exp_sip[s-1] = 1;
            if (base == 'h1D00) exp_cip[s-1] = 1;
            if (base == 'h1E00) exp_sie[s-1] = 1;
            if (base == 'h1F00) exp_cie[s-1] = 1;
          end
          if (!w) begin
            if (base == 'h1C00) exp_rdata[bt] = pend_s[s-1];
            if (base == 'h1D00) exp_rdata[bt] = lvl_s[s-1];
            if (base == 'h1E00) exp_rdata[bt] = en_s[s-1];
          end
        end
      end
    end else if (a == 'h1CDC || a == 'h2000 || a == 'h2004 || a == 'h1DDC ||
                 a == 'h1EDC || a == 'h1FDC) begin
      exp_tag = "R8";
      if (w) begin
        n = (a == 'h2004) ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
        if (n >= 1 && n <= NSRC) begin
          if (a == 'h1CDC || a == 'h2000 || a == 'h2004) exp_sip[n-1] = 1;
          if (a == 'h1DDC) exp_cip[n-1] = 1;
          if (a == 'h1EDC) exp_sie[n-1] = 1;
          if (a == 'h1FDC) exp_cie[n-1] = 1;
        end
      end
    end else begin
      exp_err = 1; exp_tag = "R2";
    end
  endtask

  // bench source model applies the pulses on the next edge, then the model sees the access
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_s <= '0; en_s <= '0;
      ie_m = 0; exp_valid = 0; exp_err = 0; exp_rdata = 0;
      exp_sip = '0; exp_cip = '0; exp_sie = '0; exp_cie = '0;
      for (int s = 1; s <= NSRC; s++) begin mode_m[s] = 0; tgt_m[s] = 0; end
    end else begin
      pend_s <= (pend_s | sip) & ~cip;
      en_s   <= (en_s | sie) & ~cie;
      if (req) model(we, int'(addr), be, wdata);
      else begin
        exp_valid = 0; exp_err = 0; exp_rdata = 0; exp_tag = "R9";
        exp_sip = '0; exp_cip = '0; exp_sie = '0; exp_cie = '0;
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9", "rsp_valid", 64'(rsp_valid), 64'(exp_valid));
      chk(exp_tag, "rsp_err", 64'(rsp_err), 64'(exp_err));
      chk(exp_tag, "rdata", 64'(rdata), 64'(exp_rdata));
      chk(exp_tag, "set_ip", 64'(sip), 64'(exp_sip));
      chk(exp_tag, "clr_ip", 64'(cip), 64'(exp_cip));
      chk(exp_tag, "set_ie", 64'(sie), 64'(exp_sie));
      chk(exp_tag, "clr_ie", 64'(cie), 64'(exp_cie));
      chk("R3", "ie", 64'(ie), 64'(ie_m));
      for (int s = 1; s <= NSRC; s++) begin
        if (mode_v[(s-1)*3 +: 3] !== 3'(mode_m[s]))
          chk("R4", $sformatf("mode src %0d", s), 64'(mode_v[(s-1)*3 +: 3]), 64'(mode_m[s]));
        if (tgt_v[(s-1)*32 +: 32] !== tgt_m[s])
          chk("R5", $sformatf("target src %0d", s), 64'(tgt_v[(s-1)*32 +: 32]), 64'(tgt_m[s]));
      end
      checks += 2;
    end
  end

  task automatic acc(input bit w, input int unsigned a, input logic [31:0] d,
                     input logic [3:0] b = 4'hF);
    req = 1; we = w; addr = AW'(a); wdata = d; be = b;
    @(negedge clk);
    req = 0; we = 0; be = 4'hF;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'h1ACE_B00C;
    int unsigned pick [18] = '{'h0, 'h4, 'h50, 'hA0, 'h3004, 'h3080, 'h30A0,
                               'h1C00, 'h1C04, 'h1D00, 'h1D04, 'h1E00, 'h1E04,
                               'h1F04, 'h1CDC, 'h2004, 'h1DDC, 'h1FDC};
    lvl_s = '0;
    idle(3);
    rst_n = 1;
    idle(2);
    // R3 domain config
    acc(0, 'h0, 0);
    acc(1, 'h0, 32'hFFFF_FFFF);
    acc(0, 'h0, 0);
    acc(1, 'h0, 32'h0000_FEFF);
    acc(0, 'h0, 0);
    // R4 mode array, delegate bit, first and last source
    acc(1, 'h4, 32'h6);
    acc(1, 'hA0, 32'h407);
    acc(1, 'h14, 32'h0000_0BFD);
    acc(0, 'h4, 0); acc(0, 'hA0, 0); acc(0, 'h14, 0);
    // R5 target mask
    acc(1, 'h3004, 32'hFFFF_FFFF);
    acc(1, 'h30A0, 32'h1234_5FFF);
    acc(0, 'h3004, 0); acc(0, 'h30A0, 0);
    // R6/R7 set-pending bitmap then immediate read (old state), then later read
    acc(1, 'h1C00, 32'hFFFF_FFFF);
    acc(0, 'h1C00, 0);
    acc(0, 'h1C00, 0);
    acc(1, 'h1C04, 32'hFFFF_FFFF);
    acc(0, 'h1C04, 0);
    acc(0, 'h1C04, 0);
    acc(1, 'h1D04, 32'h0000_0101);
    acc(0, 'h1C04, 0);
    acc(1, 'h1D00, 32'h5555_5555);
    acc(0, 'h1C00, 0);
    // R7 input levels and clear-enable window
    lvl_s = 40'hA5_0F0F_3C3C;
    acc(0, 'h1D00, 0); acc(0, 'h1D04, 0);
    acc(1, 'h1E00, 32'h8000_0003); acc(0, 'h1E00, 0); acc(0, 'h1E00, 0);
    acc(0, 'h1F00, 0);
    // R8 number ports
    acc(1, 'h1CDC, 2); acc(1, 'h2000, 33); acc(1, 'h2004, 32'h2800_0000);
    acc(1, 'h2004, 40); acc(1, 'h1CDC, 0); acc(1, 'h1CDC, 41);
    acc(1, 'h1DDC, 3); acc(1, 'h1EDC, 40); acc(1, 'h1FDC, 1); acc(1, 'h1FDC, 0);
    acc(0, 'h1CDC, 0); acc(0, 'h2004, 0); acc(0, 'h1FDC, 0); acc(0, 'h1C04, 0);
    // R1 and R2 errors
    acc(1, 'h1C02, 32'hFFFF_FFFF); acc(0, 'h1C00, 0, 4'h3); acc(1, 'h0, 32'h100, 4'h1);
    acc(0, 'h1C08, 0); acc(0, 'hA4, 0); acc(1, 'h3000, 1); acc(0, 'h7FFC, 0);
    acc(0, 'h0, 0);
    // mixed accesses
    for (int i = 0; i < 400; i++) begin
      int unsigned a;
      logic [31:0] d;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = pick[lfsr[4:0] % 18];
      d = {lfsr[15:0], lfsr[31:16]};
      if (a == 'h1CDC || a == 'h1DDC || a == 'h1FDC) d = d % 48;
      if (lfsr[9:7] == 0) lvl_s = {lfsr[7:0], lfsr};
      acc(lfsr[6], (lfsr[10:8] == 0) ? a + 2 : a, d, (lfsr[13:11] == 0) ? 4'hC : 4'hF);
      if (lfsr[14]) idle(1);
    end
    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule